// File: doc/BRIEF.md
# Serial Quad DAC Sample Transmitter

This block is a serial-bus master that delivers 12-bit unsigned samples to a four-channel digital-to-analog converter sitting on a bus it shares with other devices. A producer presents a sample, a 4-bit channel address and a valid strobe. The block takes the sample when it is ready and wraps it in a 32-bit write-and-update frame. It then clocks the frame out on a serial clock and a data line while holding the converter's active-low select asserted. The converter updates its output when the select goes high again.

For the whole time the block runs, it holds the other devices on the shared bus in their disabled state. These are the serial flash, the amplifier, the ADC, the parallel flash and the platform flash. It also drives the converter's active-low asynchronous clear line. That line is held low during reset and released one system clock after reset ends. The serial clock runs at the system clock divided by twice `SCLK_HALF`. The select stays high for at least two system clocks between frames.

Top module: `dac_frame_tx`

## Requirements
- R1: Each frame carries exactly 32 bits, most significant first. Frame bit 31 goes first. Bits [31:24] are zero, bits [23:20] hold the command, bits [19:16] hold the channel address, bits [15:4] hold the sample and bits [3:0] are zero.
- R2: The command field of every frame is binary 0011, the write-and-update-now command.
- R3: The sample and address are captured in the cycle `smp_valid` and `smp_ready` are both high. Changes on `smp_data` or `smp_chan` after that cycle do not alter the frame being sent. Address 4'hF, meaning all channels, is sent unchanged like any other address.
- R4: `sclk` is low whenever `dac_sel_n` is high. `mosi` changes only while `sclk` is low, so it is stable across every rising edge of `sclk`.
- R5: `dac_sel_n` goes low in the cycle after a sample is accepted and stays low for exactly 32 rising edges of `sclk`. The converter starts converting on the rising edge of `dac_sel_n`.
- R6: `smp_ready` is low from the cycle after acceptance until after the select has been released. While `smp_ready` is low, `smp_valid` is ignored, so one accepted sample gives exactly one frame.
- R7: Between two frames, `dac_sel_n` stays high for at least two system clock cycles.
- R8: `dac_clr_n` is low while `rst_n` is low and is high from the first clock edge after `rst_n` goes high.
- R9: The other bus devices are held disabled at all times: `flash_sel_n` = 1, `amp_sel_n` = 1, `adc_conv` = 0, `pflash_en_n` = 1 and `pcfg_init_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | 12 | Unsigned sample value |
| smp_chan | input | 4 | Channel address, 4'hF selects all |
| smp_ready | output | 1 | Block can take a sample |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| dac_sel_n | output | 1 | Active-low converter select |
| dac_clr_n | output | 1 | Active-low asynchronous clear to the converter |
| flash_sel_n | output | 1 | Serial flash select, held high |
| amp_sel_n | output | 1 | Amplifier select, held high |
| adc_conv | output | 1 | ADC convert line, held low |
| pflash_en_n | output | 1 | Parallel flash enable, held high |
| pcfg_init_n | output | 1 | Platform flash init line, held high |

## Verification
The hardest cases to reach from the ports are the ones that involve the boundaries between frames. One is a producer that keeps `smp_valid` high, with changing data, for the whole time a frame is in flight. Another is a new sample offered in the very first cycle that `smp_ready` returns. The bench holds a junk valid strobe across a busy frame and then checks that no extra frame appears. It also issues samples back to back as soon as ready rises, so that the minimum select-high gap is hit exactly. Every transfer is rebuilt from the `mosi` bits sampled on rising `sclk` edges and compared with a frame computed from the accepted sample.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    localparam int unsigned PRE_PAD_W  = 8;
    localparam int unsigned CMD_W      = 4;
    localparam int unsigned POST_PAD_W = 4;
    localparam logic [CMD_W-1:0] CMD_WRITE_UPDATE = 4'b0011;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } tx_state_e;

endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
    import dac_tx_pkg::*;
#(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned FRAME_W = PRE_PAD_W + CMD_W + ADDR_W + DATA_W + POST_PAD_W
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [FRAME_W-1:0] frame_o
);

    // Pads are zero so the data line is deterministic outside payload bits.
    always_comb begin
        frame_o = {{PRE_PAD_W{1'b0}}, CMD_WRITE_UPDATE, addr_i, data_i, {POST_PAD_W{1'b0}}};
    end

endmodule

// File: rtl/dac_clr_release.sv
module dac_clr_release (
    input  logic clk,
    input  logic rst_n,
    output logic clr_n_o
);

    logic clr_d;
    logic clr_q;

    always_comb begin
        clr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= clr_d;
        end
    end

    assign clr_n_o = clr_q;

endmodule

// File: rtl/dac_shift_ctrl.sv
module dac_shift_ctrl
    import dac_tx_pkg::*;
#(
    parameter int unsigned FRAME_W    = 32,
    parameter int unsigned SCLK_HALF  = 2,
    parameter int unsigned GAP_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               ready_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               sel_n_o
);

    localparam int unsigned BIT_W = $clog2(FRAME_W);
    localparam int unsigned DIV_W = $clog2(SCLK_HALF) + 1;
    localparam int unsigned GAP_W = $clog2(GAP_CYCLES) + 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(SCLK_HALF - 1);
    localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_CYCLES - 1);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sh;
        logic [BIT_W-1:0]   nbit;
        logic [DIV_W-1:0]   div;
        logic [GAP_W-1:0]   gap;
        logic               sclk;
        logic               sel_n;
    } ctrl_s;

    ctrl_s d;
    ctrl_s q;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (load_i) begin
                    d.st    = ST_SHIFT;
                    d.sh    = frame_i;
                    d.sel_n = 1'b0;
                    d.sclk  = 1'b0;
                    d.nbit  = '0;
                    d.div   = '0;
                end
            end
            ST_SHIFT: begin
                if (q.div == DIV_END) begin
                    d.div = '0;
                    if (!q.sclk) begin
                        d.sclk = 1'b1;              // converter samples here
                    end else begin
                        d.sclk = 1'b0;              // data moves here
                        if (q.nbit == LAST_BIT) begin
                            d.st    = ST_GAP;
                            d.sel_n = 1'b1;
                            d.gap   = '0;
                            d.sh    = '0;
                        end else begin
                            d.nbit = q.nbit + 1'b1;
                            d.sh   = {q.sh[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.gap == GAP_END) begin
                    d.st = ST_IDLE;
                end else begin
                    d.gap = q.gap + 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sh: '0, nbit: '0, div: '0, gap: '0,
                   sclk: 1'b0, sel_n: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign ready_o = (q.st == ST_IDLE);
    assign sclk_o  = q.sclk;
    assign mosi_o  = q.sh[FRAME_W-1];
    assign sel_n_o = q.sel_n;

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned SCLK_HALF  = 2,
    parameter int unsigned GAP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [ADDR_W-1:0] smp_chan,
    output logic              smp_ready,
    output logic              sclk,
    output logic              mosi,
    output logic              dac_sel_n,
    output logic              dac_clr_n,
    output logic              flash_sel_n,
    output logic              amp_sel_n,
    output logic              adc_conv,
    output logic              pflash_en_n,
    output logic              pcfg_init_n
);

    localparam int unsigned FRAME_W = PRE_PAD_W + CMD_W + ADDR_W + DATA_W + POST_PAD_W;

    logic [FRAME_W-1:0] frame;
    logic               load;

    assign load = smp_valid && smp_ready;

    dac_frame_pack #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .FRAME_W(FRAME_W)
    ) u_pack (
        .data_i (smp_data),
        .addr_i (smp_chan),
        .frame_o(frame)
    );

    dac_shift_ctrl #(
        .FRAME_W   (FRAME_W),
        .SCLK_HALF (SCLK_HALF),
        .GAP_CYCLES(GAP_CYCLES)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .frame_i(frame),
        .ready_o(smp_ready),
        .sclk_o (sclk),
        .mosi_o (mosi),
        .sel_n_o(dac_sel_n)
    );

    dac_clr_release u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n_o(dac_clr_n)
    );

    // The block is the only master of the shared bus: keep every other device off it.
    assign flash_sel_n = 1'b1;
    assign amp_sel_n   = 1'b1;
    assign adc_conv    = 1'b0;
    assign pflash_en_n = 1'b1;
    assign pcfg_init_n = 1'b1;

endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic smp_ready,
    input logic sclk,
    input logic mosi,
    input logic dac_sel_n,
    input logic dac_clr_n
);

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sel_n |-> !sclk);

    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_sel_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !dac_sel_n);

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sel_n |-> !smp_ready);

    assert_sel_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sel_n) |=> dac_sel_n);

    assert_clr_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dac_clr_n);

endmodule

bind dac_frame_tx dac_frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .sclk     (sclk),
    .mosi     (mosi),
    .dac_sel_n(dac_sel_n),
    .dac_clr_n(dac_clr_n)
);

// File: tb/dac_frame_tx_bench.sv
module dac_frame_tx_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [3:0]  smp_chan = '0;
    logic        smp_ready, sclk, mosi, dac_sel_n, dac_clr_n;
    logic        flash_sel_n, amp_sel_n, adc_conv, pflash_en_n, pcfg_init_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_frame_tx u_dac_frame_tx (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .smp_ready(smp_ready), .sclk(sclk), .mosi(mosi),
        .dac_sel_n(dac_sel_n), .dac_clr_n(dac_clr_n), .flash_sel_n(flash_sel_n),
        .amp_sel_n(amp_sel_n), .adc_conv(adc_conv), .pflash_en_n(pflash_en_n),
        .pcfg_init_n(pcfg_init_n)
    );

    int total = 0;
    int fails = 0;
    int sent = 0;
    int seen = 0;
    bit done = 1'b0;
    logic [31:0] expq[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input logic [11:0] d, input logic [3:0] c);
        return {8'h00, 4'b0011, c, d, 4'h0};
    endfunction

    function automatic bit others_off();
        return flash_sel_n && amp_sel_n && !adc_conv && pflash_en_n && pcfg_init_n;
    endfunction

    // Frame monitor: rebuilds each frame from mosi at rising sclk.
    logic [31:0] cap = '0;
    int  nbits = 0;
    int  gapc = 100;
    bit  prev_sel = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
    bit  bad_edge = 1'b0, bad_off = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sel && !dac_sel_n) begin
                chk(gapc >= 2, "R7 select high gap", gapc, 2);
                cap = '0; nbits = 0; bad_edge = 1'b0; bad_off = 1'b0;
            end
            if (!dac_sel_n && sclk && !prev_sclk) begin
                cap = {cap[30:0], mosi};
                nbits++;
            end
            if (sclk && prev_sclk && (mosi != prev_mosi)) bad_edge = 1'b1;
            if (dac_sel_n && sclk) bad_edge = 1'b1;
            if (!others_off()) bad_off = 1'b1;
            if (!prev_sel && dac_sel_n) begin
                logic [31:0] e;
                seen++;
                e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
                chk(nbits == 32, "R5 rising sclk edges per frame", nbits, 32);
                chk(cap == e, "R1 R3 frame contents", cap, e);
                chk(cap[23:20] == 4'b0011, "R2 command field", cap[23:20], 4'b0011);
                chk(!bad_edge, "R4 sclk idle and mosi timing", bad_edge, 0);
                chk(!bad_off, "R9 other devices disabled", bad_off, 0);
            end
            gapc = dac_sel_n ? gapc + 1 : 0;
            prev_sel = dac_sel_n; prev_sclk = sclk; prev_mosi = mosi;
        end
    end

    task automatic send(input logic [11:0] d, input logic [3:0] c);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1; smp_data = d; smp_chan = c;
        expq.push_back(exp_frame(d, c));
        sent++;
        @(negedge clk);
        chk(!smp_ready, "R6 ready low after acceptance", smp_ready, 0);
        smp_valid = 1'b0;
        smp_data = 12'($urandom);
        smp_chan = 4'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(dac_clr_n == 1'b0, "R8 clear low in reset", dac_clr_n, 0);
        chk(dac_sel_n == 1'b1, "R5 select high in reset", dac_sel_n, 1);
        chk(sclk == 1'b0, "R4 sclk low in reset", sclk, 0);
        chk(others_off(), "R9 disables in reset", others_off(), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_clr_n == 1'b1, "R8 clear released", dac_clr_n, 1);
        chk(smp_ready == 1'b1, "R6 ready after reset", smp_ready, 1);

        send(12'h000, 4'h0);
        send(12'hFFF, 4'hF);            // all-channels address, full-scale data
        send(12'hA5A, 4'h3);
        // Valid held with junk while busy must not start a frame (R6)
        send(12'h123, 4'h2);
        smp_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            smp_data = 12'($urandom); smp_chan = 4'($urandom);
            @(negedge clk);
            if (i % 10 == 0) chk(!smp_ready && !dac_sel_n, "R6 busy ignores valid", smp_ready, 0);
        end
        smp_valid = 1'b0;
        // Back-to-back issue at the earliest ready (R7 boundary)
        send(12'h800, 4'h1);
        send(12'h7FF, 4'h1);
        send(12'h001, 4'hF);
        for (int i = 0; i < 20; i++) begin
            send(12'($urandom), 4'($urandom));
            repeat ($urandom % 5) @(negedge clk);
        end
        @(negedge clk);
        while (!smp_ready || !dac_sel_n) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(seen == sent, "R6 one frame per accepted sample", seen, sent);
        chk(expq.size() == 0, "R3 no frame left unsent", expq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", seen, sent);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule